// File: doc/BRIEF.md
# Dual-Order Power Rail Sequencer

This controller brings up four supply rail groups of a device one group at a time and then reports that power-up is complete. A strap input chooses between two orderings. In the core-first ordering the core logic supply comes up first. In the IO-first ordering the 1.8 V IO and analog supplies come up first. In both orderings the DDR / 1.5 V group is switched on last. Before the next group is switched on, the current group's power-good input must be high and a settle delay, set at an input, must have elapsed.

A run begins when the start request rises while the controller is idle. The ordering strap is captured at that moment and held until the run ends. A group that fails to report power-good within a fixed timeout raises the fault flag. The same happens if any group loses power-good after power-up has finished. On a fault, the enabled groups are switched off one per cycle in the reverse of the order they came up. The same reverse shutdown follows when the start request is dropped, and then no fault is flagged.

Top module: `rail_sequencer`

## Requirements
- R1: After reset, all four rail enables, `done_o` and `fault_o` are low.
- R2: With `order_sel_i` = 0 (core-first), the enables rise in the order bit 0 (core), bit 1 (secondary core + SerDes), bit 2 (1.8 V IO + analog), bit 3 (DDR / 1.5 V).
- R3: With `order_sel_i` = 1 (IO-first), the enables rise in the order bit 2, bit 0, bit 1, bit 3.
- R4: The first enable is high in the cycle after the clock edge that samples `start_i` high in idle. If the current group's power-good is sampled high at edge A, the next enable is high after edge A + `settle_i` + 1.
- R5: Each step adds exactly one group. Bit 3 is never high unless bits 0 to 2 are high.
- R6: `done_o` rises at the same edge at which the last group's settle delay ends. It stays high while `start_i` stays high, and it falls at the edge that samples `start_i` low.
- R7: If the current group's power-good is still low `TIMEOUT_CYCLES` edges after its enable rose, `fault_o` is set at that edge.
- R8: After a fault, or after `start_i` is dropped, the group enabled last goes off one cycle after the triggering edge. The remaining groups follow one per cycle in reverse order.
- R9: `fault_o` stays high, and no new power-up begins, while `start_i` stays high. `fault_o` clears at the edge that samples `start_i` low in idle.
- R10: `order_sel_i` is sampled only when leaving idle. Changing it during a run has no effect on the order.
- R11: While `done_o` is high, any power-good input sampled low sets `fault_o` at that edge, and the reverse shutdown follows.
- R12: Dropping `start_i` during power-up or after done shuts the groups down in reverse order without setting `fault_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Power-up request, held high for the whole run |
| order_sel_i | input | 1 | Ordering strap: 0 core-first, 1 IO-first |
| settle_i | input | SETTLE_W | Settle delay in cycles after power-good |
| pgood_i | input | 4 | Power-good per rail group (bit = group) |
| rail_en_o | output | 4 | Enable per rail group |
| done_o | output | 1 | Power-up complete |
| fault_o | output | 1 | Timeout or power-good loss seen |

## Verification
A wrong stage pointer shows up at the ports within one cycle. It appears as a missing, extra or misplaced enable bit, and the bench compares every enable bit against the arithmetic schedule on every cycle. A timer or settle counter that is off by one moves a rising enable, the done edge or the fault edge by one cycle, and the bench checks each of these at its exact cycle. A captured ordering that is wrong or drifting appears at the second stage of the run. A shutdown index that is wrong appears in the first cycle after the fault or after the drop of the start request.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
   localparam int unsigned RSEQ_GROUPS = 4;
   localparam int unsigned RSEQ_STAGES = 4;
   localparam int unsigned GRP_W       = $clog2(RSEQ_GROUPS);
   localparam int unsigned LVL_W       = $clog2(RSEQ_STAGES + 1);

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_WAIT   = 3'd1,
      ST_SETTLE = 3'd2,
      ST_DONE   = 3'd3,
      ST_DOWN   = 3'd4
   } rseq_state_e;

   typedef enum logic {
      ORD_CORE_FIRST = 1'b0,
      ORD_IO_FIRST   = 1'b1
   } rseq_order_e;

   // Rail group switched on at a given stage under a given ordering.
   // Group 3 (DDR / 1.5 V) is last in both orderings.
   function automatic logic [GRP_W-1:0] stage_group(rseq_order_e ord, int unsigned stage);
      logic [GRP_W-1:0] g;
      if (ord == ORD_CORE_FIRST) begin
         g = GRP_W'(stage);
      end else begin
         case (stage)
            0:       g = GRP_W'(2);
            1:       g = GRP_W'(0);
            2:       g = GRP_W'(1);
            default: g = GRP_W'(3);
         endcase
      end
      return g;
   endfunction
endpackage

// File: rtl/rseq_order_map.sv
module rseq_order_map
   import rseq_pkg::*;
(
   input  rseq_order_e                order_i,
   input  logic [LVL_W-1:0]           lvl_i,
   output logic [RSEQ_GROUPS-1:0]     en_o,
   output logic [GRP_W-1:0]           cur_grp_o
);
   logic [RSEQ_GROUPS-1:0] stage_oh [RSEQ_STAGES];
   logic [LVL_W-1:0]       lvl_m1;

   initial begin
      assert (RSEQ_STAGES == RSEQ_GROUPS)
         else $error("rseq_order_map: each stage must own exactly one group");
   end

   for (genvar s = 0; s < RSEQ_STAGES; s++) begin : g_stage
      localparam logic [LVL_W-1:0] S_LVL = LVL_W'(s);
      assign stage_oh[s] = (lvl_i > S_LVL)
                         ? (RSEQ_GROUPS'(1) << stage_group(order_i, s))
                         : '0;
   end

   always_comb begin
      en_o = '0;
      for (int s = 0; s < RSEQ_STAGES; s++) begin
         en_o = en_o | stage_oh[s];
      end
   end

   assign lvl_m1 = lvl_i - LVL_W'(1);

   always_comb begin
      if (lvl_i == '0) cur_grp_o = '0;
      else             cur_grp_o = stage_group(order_i, 32'(lvl_m1));
   end
endmodule

// File: rtl/rseq_fsm.sv
module rseq_fsm
   import rseq_pkg::*;
#(
   parameter int unsigned TIMEOUT_CYCLES = 1000,
   parameter int unsigned SETTLE_W       = 8
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              order_sel_i,
   input  logic [SETTLE_W-1:0] settle_i,
   input  logic              cur_pg_i,
   input  logic              all_pg_i,
   output rseq_order_e       order_o,
   output logic [LVL_W-1:0]  lvl_o,
   output logic              done_o,
   output logic              fault_o
);
   localparam int unsigned TMO_W    = $clog2(TIMEOUT_CYCLES);
   localparam int unsigned CNT_W    = (TMO_W > SETTLE_W) ? TMO_W : SETTLE_W;
   localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TIMEOUT_CYCLES - 1);
   localparam logic [LVL_W-1:0] LVL_TOP  = LVL_W'(RSEQ_STAGES);

   rseq_state_e       state_q;
   rseq_order_e       order_q;
   logic [LVL_W-1:0]  lvl_q;
   logic [CNT_W-1:0]  tmr_q;
   logic              fault_q;

   initial begin
      assert (TIMEOUT_CYCLES >= 2) else $error("rseq_fsm: TIMEOUT_CYCLES below 2");
      assert (SETTLE_W >= 1)       else $error("rseq_fsm: SETTLE_W below 1");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         order_q <= ORD_CORE_FIRST;
         lvl_q   <= '0;
         tmr_q   <= '0;
         fault_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               tmr_q <= '0;
               if (!start_i) begin
                  fault_q <= 1'b0;
               end else if (!fault_q) begin
                  order_q <= rseq_order_e'(order_sel_i);
                  lvl_q   <= LVL_W'(1);
                  state_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (!start_i) begin
                  state_q <= ST_DOWN;
               end else if (cur_pg_i) begin
                  tmr_q   <= '0;
                  state_q <= ST_SETTLE;
               end else if (tmr_q == TMO_LAST) begin
                  fault_q <= 1'b1;
                  state_q <= ST_DOWN;
               end else begin
                  tmr_q <= tmr_q + CNT_W'(1);
               end
            end
            ST_SETTLE: begin
               if (!start_i) begin
                  state_q <= ST_DOWN;
               end else if (tmr_q == CNT_W'(settle_i)) begin
                  tmr_q <= '0;
                  if (lvl_q == LVL_TOP) begin
                     state_q <= ST_DONE;
                  end else begin
                     lvl_q   <= lvl_q + LVL_W'(1);
                     state_q <= ST_WAIT;
                  end
               end else begin
                  tmr_q <= tmr_q + CNT_W'(1);
               end
            end
            ST_DONE: begin
               if (!all_pg_i) begin
                  fault_q <= 1'b1;
                  state_q <= ST_DOWN;
               end else if (!start_i) begin
                  state_q <= ST_DOWN;
               end
            end
            ST_DOWN: begin
               if (lvl_q <= LVL_W'(1)) state_q <= ST_IDLE;
               if (lvl_q != '0)        lvl_q   <= lvl_q - LVL_W'(1);
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign order_o = order_q;
   assign lvl_o   = lvl_q;
   assign done_o  = (state_q == ST_DONE);
   assign fault_o = fault_q;

   a_r7_wait_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_WAIT) |-> (tmr_q <= TMO_LAST));
   a_r10_order_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q != ST_IDLE) |=> $stable(order_q));
   a_r9_no_restart_on_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fault_q && state_q == ST_IDLE) |=> (state_q == ST_IDLE));
   a_r11_loss_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_DONE && !all_pg_i) |=> (fault_q && state_q == ST_DOWN));
   a_r6_done_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !start_i) |=> !done_o);
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
   import rseq_pkg::*;
#(
   parameter int unsigned TIMEOUT_CYCLES = 1000,
   parameter int unsigned SETTLE_W       = 8
)(
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   start_i,
   input  logic                   order_sel_i,
   input  logic [SETTLE_W-1:0]    settle_i,
   input  logic [RSEQ_GROUPS-1:0] pgood_i,
   output logic [RSEQ_GROUPS-1:0] rail_en_o,
   output logic                   done_o,
   output logic                   fault_o
);
   rseq_order_e       order_w;
   logic [LVL_W-1:0]  lvl_w;
   logic [GRP_W-1:0]  cur_grp_w;
   logic              cur_pg_w;
   logic              all_pg_w;

   assign cur_pg_w = pgood_i[cur_grp_w];
   assign all_pg_w = &pgood_i;

   rseq_fsm #(
      .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
      .SETTLE_W       (SETTLE_W)
   ) fsm_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (start_i),
      .order_sel_i (order_sel_i),
      .settle_i    (settle_i),
      .cur_pg_i    (cur_pg_w),
      .all_pg_i    (all_pg_w),
      .order_o     (order_w),
      .lvl_o       (lvl_w),
      .done_o      (done_o),
      .fault_o     (fault_o)
   );

   rseq_order_map map_i (
      .order_i   (order_w),
      .lvl_i     (lvl_w),
      .en_o      (rail_en_o),
      .cur_grp_o (cur_grp_w)
   );

   a_r5_single_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(rail_en_o & ~$past(rail_en_o)) <= 1);
   a_r5_ddr_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rail_en_o[3] |-> (&rail_en_o[2:0]));
   a_r8_single_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones($past(rail_en_o) & ~rail_en_o) <= 1);
   a_r6_done_all_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (&rail_en_o && !fault_o));
   a_r9_fault_no_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_o |-> ((rail_en_o & ~$past(rail_en_o)) == '0));
endmodule

// File: tb/rail_sequencer_tb_top.sv
`timescale 1ns/100ps
module rail_sequencer_tb_top;
   localparam int TMO = 12;
   localparam int SW  = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          order_sel = 1'b0;
   logic [SW-1:0] settle = '0;
   logic [3:0]    pgood = '0;
   logic [3:0]    rail_en;
   logic          done;
   logic          fault;

   int checks = 0;
   int fails  = 0;
   int dly    = 1;
   logic [3:0] blk = '0;
   int pcnt [4];

   always #2.5 clk = ~clk;

   rail_sequencer #(.TIMEOUT_CYCLES(TMO), .SETTLE_W(SW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .order_sel_i(order_sel),
      .settle_i(settle), .pgood_i(pgood), .rail_en_o(rail_en),
      .done_o(done), .fault_o(fault));

   // Rail model: power-good follows enable after dly falling edges unless blocked.
   initial begin
      for (int g = 0; g < 4; g++) pcnt[g] = 0;
      forever begin
         @(negedge clk);
         for (int g = 0; g < 4; g++) begin
            if (rail_en[g] && !blk[g]) begin
               if (pcnt[g] < 1000) pcnt[g]++;
            end else begin
               pcnt[g] = 0;
            end
            pgood[g] = (pcnt[g] >= dly);
         end
      end
   end

   function automatic int grp_of(int ord, int stage);
      int io_tab [4] = '{2, 0, 1, 3};
      return (ord == 0) ? stage : io_tab[stage];
   endfunction

   function automatic logic [3:0] exp_mask(int ord, int n);
      logic [3:0] m = '0;
      for (int s = 0; s < n && s < 4; s++) m[grp_of(ord, s)] = 1'b1;
      return m;
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string tag, logic [3:0] em, logic ed, logic ef);
      checks++;
      if (rail_en !== em || done !== ed || fault !== ef) begin
         fails++;
         $display("FAIL %s: en=%b done=%b fault=%b, expected en=%b done=%b fault=%b",
                  tag, rail_en, done, fault, em, ed, ef);
      end
   endtask

   // Full power-up; returns with done just observed (posedge + 1 ns).
   task automatic powerup(int ord, int s, int d, int flip_c);
      int p;
      p = d + s + 1;
      @(negedge clk);
      dly = d; settle = SW'(s); order_sel = ord[0]; start = 1'b1;
      for (int c = 0; c <= 4 * p; c++) begin
         int n;
         tick();
         n = c / p + 1;
         if (n > 4) n = 4;
         chk(ord == 0 ? "R2 R4 R5 R6 core-first" : "R3 R4 R5 R6 io-first",
             exp_mask(ord, n), (c == 4 * p), 1'b0);
         if (c == flip_c) order_sel = ~order_sel;
      end
   endtask

   task automatic shutdown(int ord);
      start = 1'b0;
      for (int c = 0; c <= 4; c++) begin
         tick();
         chk("R8 R12 reverse shutdown", exp_mask(ord, 4 - c), 1'b0, 1'b0);
      end
      tick(); tick();
   endtask

   initial begin
      int svals [3] = '{0, 1, 3};
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset", 4'b0000, 1'b0, 1'b0);
      @(negedge clk) rst_n = 1'b1;
      tick();
      chk("R1 after release", 4'b0000, 1'b0, 1'b0);

      // Sweep orderings, settle delays and rail response delays.
      for (int ord = 0; ord < 2; ord++)
         for (int si = 0; si < 3; si++)
            for (int d = 1; d <= 2; d++) begin
               powerup(ord, svals[si], d, -1);
               for (int h = 0; h < 3; h++) begin
                  tick();
                  chk("R6 done held", 4'b1111, 1'b1, 1'b0);
               end
               shutdown(ord);
            end

      // R10: strap flips mid-run, order stays core-first.
      powerup(0, 1, 1, 2);
      shutdown(0);
      order_sel = 1'b0;

      // R7/R8/R9: second stage (group 1) never good, core-first, P = 3.
      blk = 4'b0010;
      @(negedge clk);
      dly = 1; settle = SW'(1); order_sel = 1'b0; start = 1'b1;
      for (int c = 0; c <= 3 + TMO + 2; c++) begin
         logic [3:0] em;
         tick();
         if (c < 3)                em = exp_mask(0, 1);
         else if (c <= 3 + TMO)    em = exp_mask(0, 2);
         else if (c == 3 + TMO + 1) em = exp_mask(0, 1);
         else                      em = 4'b0000;
         chk("R7 R8 timeout stage 2", em, 1'b0, (c >= 3 + TMO));
      end
      for (int h = 0; h < 4; h++) begin
         tick();
         chk("R9 fault held, no restart", 4'b0000, 1'b0, 1'b1);
      end
      start = 1'b0;
      tick();
      chk("R9 fault cleared", 4'b0000, 1'b0, 1'b0);
      blk = '0;
      tick();

      // R7: first stage of IO-first (group 2) never good.
      blk = 4'b0100;
      @(negedge clk);
      dly = 1; settle = SW'(0); order_sel = 1'b1; start = 1'b1;
      for (int c = 0; c <= TMO + 2; c++) begin
         tick();
         chk("R7 timeout stage 1", (c <= TMO) ? 4'b0100 : 4'b0000, 1'b0, (c >= TMO));
      end
      start = 1'b0;
      tick();
      chk("R9 fault cleared io-first", 4'b0000, 1'b0, 1'b0);
      blk = '0;
      tick();

      // R9: restart works after fault cleared.
      powerup(1, 0, 1, -1);

      // R11: power-good loss after done (IO-first run still up).
      blk = 4'b0010;
      for (int c = 1; c <= 5; c++) begin
         tick();
         chk("R11 R8 pgood loss after done", exp_mask(1, (c == 1) ? 4 : 5 - c), 1'b0, 1'b1);
      end
      start = 1'b0;
      tick();
      chk("R11 fault cleared", 4'b0000, 1'b0, 1'b0);
      blk = '0;
      tick();

      // R12: abort during stage 2 wait, IO-first, d = 2, s = 0, P = 3.
      @(negedge clk);
      dly = 2; settle = SW'(0); order_sel = 1'b1; start = 1'b1;
      for (int c = 0; c <= 4; c++) begin
         tick();
         chk("R12 before abort", exp_mask(1, (c < 3) ? 1 : 2), 1'b0, 1'b0);
      end
      start = 1'b0;
      for (int c = 5; c <= 7; c++) begin
         tick();
         chk("R12 abort shutdown", exp_mask(1, 7 - c), 1'b0, 1'b0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule